// File: doc/BRIEF.md
# Snooping Four-State Coherent Data Cache Controller

This controller sits between one processor core and a shared snooping bus. It manages a direct-mapped, copy-back data cache whose lines hold one data word each. Every line carries one of four coherence states: Invalid, Shared, Exclusive or Modified. The core issues single-word reads and writes. Hits are served locally. Misses, upgrades and evictions become bus transactions, and the controller obtains the bus through a request/grant handshake.

At the same time the controller watches every transaction that another cache drives onto the bus. When the snooped address matches one of its valid lines, it reports the hit on the shared-response line. It may also supply the line in place of memory, block an exclusive read while it copies a dirty line back, or invalidate its own copy. The memory model, the arbiter and the combining of the snoop responses of all caches live outside the block. The arbiter grants the lowest-numbered requester. Supplied data takes precedence over memory data, and the memory model stores any supplied word, so that a line leaving the Modified state reaches memory.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid: `core_ready` and `bus_req` are low, and the first read of any address produces exactly one bus read.
- R2: A read miss that no other cache answers installs the line in Exclusive, with the data taken from memory.
- R3: A read hit in any valid state returns the stored word, with a single-cycle `core_ready` pulse and no bus transaction.
- R4: A read miss that another cache holds in Exclusive or Shared is served by that cache, with no memory read. The supplier and the requester both end in Shared, and any other Shared copies stay Shared.
- R5: A read miss that hits a Modified copy elsewhere is supplied by that cache, and memory receives the supplied word. The supplier drops to Shared and the requester installs Shared.
- R6: A write hit in Modified or Exclusive updates the word and leaves the line Modified, with no bus transaction.
- R7: A write hit in Shared first broadcasts an invalidate. Snooping copies become Invalid, and the local line takes the data and becomes Modified.
- R8: A write miss issues an exclusive read served by memory when no Modified copy exists. Other Exclusive or Shared copies become Invalid, and the local line holds the written word in Modified.
- R9: An exclusive read that hits a Modified copy is answered with retry. The holder puts its word on the bus for memory and becomes Invalid, and the requester re-issues and ends Modified with its own word.
- R10: A conflict miss on a Modified line first writes the victim back with a write-back transaction. A clean victim is dropped with no bus transaction.
- R11: A snoop changes only a line whose tag matches the snooped address. A cache never responds to its own transaction.
- R12: Bus commands are encoded read=0, exclusive read=1, invalidate=2, write-back=3. While a fill waits for grant, command and address stay stable, and concurrent writers to one address are serialized so that the last granted writer's word survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core access request, held until `core_ready` |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | AW | Word address |
| core_wdata | input | DW | Write data |
| core_ready | output | 1 | One-cycle completion pulse |
| core_rdata | output | DW | Read data, valid with `core_ready` |
| bus_req | output | 1 | Bus request |
| bus_cmd_o | output | 2 | Command of the requested transaction |
| bus_addr_o | output | AW | Address of the requested transaction |
| bus_wdata_o | output | DW | Write-back data |
| bus_gnt | input | 1 | Grant; the current bus transaction is this cache's own |
| bus_valid | input | 1 | A transaction is on the bus this cycle |
| bus_cmd_i | input | 2 | Command on the bus |
| bus_addr_i | input | AW | Address on the bus |
| bus_rdata_i | input | DW | Data returned to the requester |
| bus_shared_i | input | 1 | OR of all snoop hit responses |
| bus_retry_i | input | 1 | OR of all snoop retry responses |
| snp_hit_o | output | 1 | This cache holds the snooped line |
| snp_supply_o | output | 1 | This cache drives the snooped line |
| snp_retry_o | output | 1 | This cache blocks the exclusive read |
| snp_data_o | output | DW | Supplied line data |

## Verification
The bench builds three controllers with AW=6, DW=16 and SETS=4. The 64-word space is small enough to sweep every address through one cache, and its 16 tags per set make same-set conflicts and tag-mismatch snoops easy to set up. Three caches make it possible to reach cases that need more than one other copy, such as a Shared copy that must survive a third cache's read and later be invalidated. The same setup covers two writers contending for one address.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_INV = 2'd2,
        BC_WB  = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_WBK,
        FS_FILL,
        FS_UPG,
        FS_DONE
    } fsm_e;

    typedef struct packed {
        logic  hit;
        logic  supply;
        logic  retry;
        mesi_e nxt;
    } snp_resp_t;

    // Reaction of a line whose tag matches a foreign transaction.
    function automatic snp_resp_t snoop_resp(mesi_e cur, bus_cmd_e cmd);
        snp_resp_t r;
        r = '{hit: 1'b0, supply: 1'b0, retry: 1'b0, nxt: cur};
        if (cur != ST_I) begin
            case (cmd)
                BC_RD: begin
                    r.hit    = 1'b1;
                    r.supply = 1'b1;
                    r.nxt    = ST_S;
                end
                BC_RDX: begin
                    r.hit = 1'b1;
                    r.nxt = ST_I;
                    if (cur == ST_M) begin
                        r.retry  = 1'b1;
                        r.supply = 1'b1;
                    end
                end
                BC_INV:  r.nxt = ST_I;
                default: ;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 5,
    parameter int DW    = 32,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    output mesi_e            a_st,
    output logic [TAG_W-1:0] a_tag,
    output logic [DW-1:0]    a_data,
    input  logic [IDX_W-1:0] b_idx,
    output mesi_e            b_st,
    output logic [TAG_W-1:0] b_tag,
    output logic [DW-1:0]    b_data,
    input  logic [IDX_W-1:0] w_idx,
    input  logic             w_st_en,
    input  logic             w_line_en,
    input  mesi_e            w_st,
    input  logic [TAG_W-1:0] w_tag,
    input  logic [DW-1:0]    w_data
);

    mesi_e            st_q   [SETS];
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [DW-1:0]    data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) st_q[i] <= ST_I;
        end else if (w_st_en) begin
            st_q[w_idx] <= w_st;
        end
    end

    always_ff @(posedge clk) begin
        if (w_line_en) begin
            tag_q[w_idx]  <= w_tag;
            data_q[w_idx] <= w_data;
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_gnt,
    input  logic [1:0]       bus_cmd,
    input  logic [TAG_W-1:0] bus_tag,
    input  mesi_e            line_st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [DW-1:0]    line_data,
    output logic             hit_o,
    output logic             supply_o,
    output logic             retry_o,
    output logic [DW-1:0]    data_o,
    output logic             st_we,
    output mesi_e            st_nxt,
    output logic             busy
);

    logic      match;
    snp_resp_t resp;

    assign busy     = bus_valid && !bus_gnt;
    assign match    = busy && (line_st != ST_I) && (line_tag == bus_tag);
    assign resp     = snoop_resp(line_st, bus_cmd_e'(bus_cmd));
    assign hit_o    = match && resp.hit;
    assign supply_o = match && resp.supply;
    assign retry_o  = match && resp.retry;
    assign data_o   = supply_o ? line_data : '0;
    assign st_we    = match && (resp.nxt != line_st);
    assign st_nxt   = resp.nxt;

    // R9: retry only blocks an exclusive read, and always carries the dirty word
    p_retry_rdx_r9: assert property (@(posedge clk) disable iff (rst)
        retry_o |-> (bus_cmd == BC_RDX) && supply_o);

    // R11: no response to the cache's own transaction
    p_quiet_own_r11: assert property (@(posedge clk) disable iff (rst)
        bus_gnt |-> !(hit_o || supply_o || retry_o || st_we));

    // R4: data is supplied only for read-type commands
    p_supply_read_r4: assert property (@(posedge clk) disable iff (rst)
        supply_o |-> (bus_cmd == BC_RD || bus_cmd == BC_RDX) && hit_o);

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 5,
    parameter int DW    = 32,
    parameter int AW    = TAG_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_req,
    input  logic             core_we,
    input  logic [TAG_W-1:0] core_tag,
    input  logic [IDX_W-1:0] core_idx,
    input  logic [DW-1:0]    core_wdata,
    output logic             core_ready,
    output logic [DW-1:0]    core_rdata,
    input  mesi_e            line_st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [DW-1:0]    line_data,
    input  logic             snp_busy,
    input  logic             bus_gnt,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_shared,
    input  logic             bus_retry,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    output logic             w_st_en,
    output logic             w_line_en,
    output mesi_e            w_st,
    output logic [TAG_W-1:0] w_tag,
    output logic [DW-1:0]    w_data
);

    fsm_e          state, nxt;
    logic [DW-1:0] rdata_q, rdata_d;
    logic          hit;

    assign hit        = (line_st != ST_I) && (line_tag == core_tag);
    assign core_ready = (state == FS_DONE);
    assign core_rdata = rdata_q;

    always_comb begin
        nxt       = state;
        rdata_d   = rdata_q;
        bus_req   = 1'b0;
        bus_cmd   = BC_RD;
        bus_addr  = {core_tag, core_idx};
        bus_wdata = line_data;
        w_st_en   = 1'b0;
        w_line_en = 1'b0;
        w_st      = ST_I;
        w_tag     = core_tag;
        w_data    = core_wdata;
        unique case (state)
            FS_IDLE: begin
                if (core_req && !snp_busy) begin
                    if (hit) begin
                        if (!core_we) begin
                            rdata_d = line_data;
                            nxt     = FS_DONE;
                        end else if (line_st == ST_S) begin
                            nxt = FS_UPG;
                        end else begin
                            w_st_en   = 1'b1;
                            w_line_en = 1'b1;
                            w_st      = ST_M;
                            nxt       = FS_DONE;
                        end
                    end else if (line_st == ST_M) begin
                        nxt = FS_WBK;
                    end else begin
                        nxt = FS_FILL;
                    end
                end
            end
            FS_WBK: begin
                if (line_st != ST_M) begin
                    nxt = FS_FILL;
                end else begin
                    bus_req  = 1'b1;
                    bus_cmd  = BC_WB;
                    bus_addr = {line_tag, core_idx};
                    if (bus_gnt) begin
                        w_st_en = 1'b1;
                        w_st    = ST_I;
                        nxt     = FS_FILL;
                    end
                end
            end
            FS_FILL: begin
                bus_req = 1'b1;
                bus_cmd = core_we ? BC_RDX : BC_RD;
                if (bus_gnt && !bus_retry) begin
                    w_st_en   = 1'b1;
                    w_line_en = 1'b1;
                    w_data    = core_we ? core_wdata : bus_rdata;
                    w_st      = core_we ? ST_M : (bus_shared ? ST_S : ST_E);
                    rdata_d   = bus_rdata;
                    nxt       = FS_DONE;
                end
            end
            FS_UPG: begin
                if (line_st != ST_S) begin
                    nxt = FS_FILL;
                end else begin
                    bus_req = 1'b1;
                    bus_cmd = BC_INV;
                    if (bus_gnt) begin
                        w_st_en   = 1'b1;
                        w_line_en = 1'b1;
                        w_st      = ST_M;
                        nxt       = FS_DONE;
                    end
                end
            end
            default: nxt = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FS_IDLE;
            rdata_q <= '0;
        end else begin
            state   <= nxt;
            rdata_q <= rdata_d;
        end
    end

    // R3: completion is a single-cycle pulse
    p_ready_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        core_ready |=> !core_ready);

    // R2: an unshared read fill leaves the line Exclusive
    p_fill_excl_r2: assert property (@(posedge clk) disable iff (rst)
        (state == FS_FILL && bus_gnt && !bus_retry && !core_we && !bus_shared)
        |=> (line_st == ST_E));

    // R10: a dirty victim is written back before any fill
    p_evict_wb_r10: assert property (@(posedge clk) disable iff (rst)
        (state == FS_IDLE && core_req && !snp_busy && !hit && line_st == ST_M)
        |=> (bus_req && bus_cmd == BC_WB));

    // R12: a waiting fill holds its command and address
    p_fill_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (state == FS_FILL && bus_req && !bus_gnt)
        |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
    import mesi_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 32,
    parameter int SETS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_ready,
    output logic [DW-1:0] core_rdata,
    output logic          bus_req,
    output logic [1:0]    bus_cmd_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic          bus_gnt,
    input  logic          bus_valid,
    input  logic [1:0]    bus_cmd_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_rdata_i,
    input  logic          bus_shared_i,
    input  logic          bus_retry_i,
    output logic          snp_hit_o,
    output logic          snp_supply_o,
    output logic          snp_retry_o,
    output logic [DW-1:0] snp_data_o
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = AW - IDX_W;

    logic [IDX_W-1:0] c_idx, b_idx, w_idx;
    logic [TAG_W-1:0] c_tag, b_tag, a_tag, bl_tag, f_tag;
    mesi_e            a_st, bl_st, f_st, s_nxt, w_st;
    logic [DW-1:0]    a_data, bl_data, f_data;
    logic             f_st_en, f_line_en, s_we, s_busy;

    assign c_idx = core_addr[IDX_W-1:0];
    assign c_tag = core_addr[AW-1:IDX_W];
    assign b_idx = bus_addr_i[IDX_W-1:0];
    assign b_tag = bus_addr_i[AW-1:IDX_W];

    // Snoop updates and core updates never share a cycle; snoop wins the port.
    assign w_idx = s_we ? b_idx : c_idx;
    assign w_st  = s_we ? s_nxt : f_st;

    mesi_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DW(DW), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .a_idx(c_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(b_idx), .b_st(bl_st), .b_tag(bl_tag), .b_data(bl_data),
        .w_idx(w_idx), .w_st_en(s_we || f_st_en), .w_line_en(f_line_en && !s_we),
        .w_st(w_st), .w_tag(f_tag), .w_data(f_data)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W), .DW(DW)) u_snoop (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd_i), .bus_tag(b_tag),
        .line_st(bl_st), .line_tag(bl_tag), .line_data(bl_data),
        .hit_o(snp_hit_o), .supply_o(snp_supply_o), .retry_o(snp_retry_o),
        .data_o(snp_data_o), .st_we(s_we), .st_nxt(s_nxt), .busy(s_busy)
    );

    mesi_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW), .AW(AW)) u_fsm (
        .clk(clk), .rst(rst),
        .core_req(core_req), .core_we(core_we), .core_tag(c_tag), .core_idx(c_idx),
        .core_wdata(core_wdata), .core_ready(core_ready), .core_rdata(core_rdata),
        .line_st(a_st), .line_tag(a_tag), .line_data(a_data), .snp_busy(s_busy),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata_i), .bus_shared(bus_shared_i),
        .bus_retry(bus_retry_i), .bus_req(bus_req), .bus_cmd(bus_cmd_o),
        .bus_addr(bus_addr_o), .bus_wdata(bus_wdata_o),
        .w_st_en(f_st_en), .w_line_en(f_line_en), .w_st(f_st), .w_tag(f_tag), .w_data(f_data)
    );

    // R12: snoop and core never update the array in the same cycle
    p_one_writer_r12: assert property (@(posedge clk) disable iff (rst)
        !(s_we && (f_st_en || f_line_en)));

endmodule

// File: tb/mesi_snoop_cache_test.sv
module mesi_snoop_cache_test;

    localparam int PERIOD = 10;
    localparam int NC     = 3;
    localparam int AW     = 6;
    localparam int DW     = 16;
    localparam int SETS   = 4;
    localparam int WORDS  = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(PERIOD / 2) clk = ~clk;

    logic [NC-1:0] core_req = '0, core_we = '0, core_ready;
    logic [NC-1:0] bus_req, bus_gnt, snp_hit, snp_supply, snp_retry;
    logic [AW-1:0] core_addr [NC];
    logic [DW-1:0] core_wdata[NC];
    logic [DW-1:0] core_rdata[NC];
    logic [1:0]    bcmd_o    [NC];
    logic [AW-1:0] baddr_o   [NC];
    logic [DW-1:0] bwdata_o  [NC];
    logic [DW-1:0] snp_data  [NC];

    logic          b_valid, any_sup;
    logic [1:0]    sel, b_cmd;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata, sup_data, b_rdata;
    logic          b_shared, b_retry;
    logic [DW-1:0] mem [WORDS];

    int n_rd, n_rdx, n_inv, n_wb, n_memrd, n_retry;
    int checks = 0, errors = 0;

    initial begin
        for (int i = 0; i < NC; i++) begin
            core_addr[i]  = '0;
            core_wdata[i] = '0;
        end
    end

    // Fixed-priority arbiter and response combining
    always_comb begin
        bus_gnt  = '0;
        sel      = '0;
        b_valid  = 1'b0;
        any_sup  = 1'b0;
        sup_data = '0;
        for (int i = 0; i < NC; i++) begin
            if (bus_req[i] && !b_valid) begin
                bus_gnt[i] = 1'b1;
                sel        = 2'(i);
                b_valid    = 1'b1;
            end
        end
        for (int i = 0; i < NC; i++) begin
            if (snp_supply[i] && !any_sup) begin
                any_sup  = 1'b1;
                sup_data = snp_data[i];
            end
        end
    end

    assign b_cmd    = bcmd_o[sel];
    assign b_addr   = baddr_o[sel];
    assign b_wdata  = bwdata_o[sel];
    assign b_rdata  = any_sup ? sup_data : mem[b_addr];
    assign b_shared = |snp_hit;
    assign b_retry  = |snp_retry;

    // Memory model and transaction counters
    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < WORDS; a++) mem[a] <= DW'(16'hA000 + a);
            n_rd <= 0; n_rdx <= 0; n_inv <= 0; n_wb <= 0; n_memrd <= 0; n_retry <= 0;
        end else if (b_valid) begin
            case (b_cmd)
                2'd0: n_rd  <= n_rd + 1;
                2'd1: n_rdx <= n_rdx + 1;
                2'd2: n_inv <= n_inv + 1;
                default: n_wb <= n_wb + 1;
            endcase
            if (b_retry) n_retry <= n_retry + 1;
            if (b_cmd == 2'd3) mem[b_addr] <= b_wdata;
            else if (any_sup) mem[b_addr] <= sup_data;
            else if (b_cmd == 2'd0 || b_cmd == 2'd1) n_memrd <= n_memrd + 1;
        end
    end

    for (genvar g = 0; g < NC; g++) begin : gen_c
        mesi_snoop_cache #(.AW(AW), .DW(DW), .SETS(SETS)) uut (
            .clk(clk), .rst(rst),
            .core_req(core_req[g]), .core_we(core_we[g]), .core_addr(core_addr[g]),
            .core_wdata(core_wdata[g]), .core_ready(core_ready[g]), .core_rdata(core_rdata[g]),
            .bus_req(bus_req[g]), .bus_cmd_o(bcmd_o[g]), .bus_addr_o(baddr_o[g]),
            .bus_wdata_o(bwdata_o[g]), .bus_gnt(bus_gnt[g]), .bus_valid(b_valid),
            .bus_cmd_i(b_cmd), .bus_addr_i(b_addr), .bus_rdata_i(b_rdata),
            .bus_shared_i(b_shared), .bus_retry_i(b_retry),
            .snp_hit_o(snp_hit[g]), .snp_supply_o(snp_supply[g]), .snp_retry_o(snp_retry[g]),
            .snp_data_o(snp_data[g])
        );
    end

    function automatic int total_tx();
        return n_rd + n_rdx + n_inv + n_wb;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic acc(input int c, input logic we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] q);
        int t;
        core_addr[c]  = a;
        core_wdata[c] = d;
        core_we[c]    = we;
        core_req[c]   = 1'b1;
        t = 0;
        while (!core_ready[c] && t < 1000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 1000) chk(1'b0, "timeout", t, 0);
        q           = core_rdata[c];
        core_req[c] = 1'b0;
        @(negedge clk);
    endtask

    logic [DW-1:0] q, q0, q1;
    int b, m, r;

    initial begin
        do_reset();
        // R1: idle outputs after reset
        chk(core_ready == '0, "R1 ready", int'(core_ready), 0);
        chk(bus_req == '0, "R1 bus_req", int'(bus_req), 0);

        // R1/R2: sweep the whole space through cache 0
        for (int a = 0; a < WORDS; a++) begin
            b = n_rd;
            acc(0, 1'b0, AW'(a), '0, q);
            chk(q == DW'(16'hA000 + a), "R1 sweep data", int'(q), 16'hA000 + a);
            chk(n_rd - b == 1, "R2 sweep miss", n_rd - b, 1);
        end
        chk(n_wb == 0, "R10 clean evict silent", n_wb, 0);
        chk(n_memrd == WORDS, "R2 memory fills", n_memrd, WORDS);

        // R2/R3/R6: exclusive then modified, all local
        do_reset();
        acc(0, 1'b0, 6'd5, '0, q);
        b = total_tx();
        acc(0, 1'b1, 6'd5, 16'h1111, q);
        chk(total_tx() == b, "R2 E write silent", total_tx() - b, 0);
        acc(0, 1'b0, 6'd5, '0, q);
        chk(q == 16'h1111, "R3 read hit data", int'(q), 16'h1111);
        chk(total_tx() == b, "R3 read hit no bus", total_tx() - b, 0);
        acc(0, 1'b1, 6'd5, 16'h2222, q);
        chk(total_tx() == b, "R6 M write silent", total_tx() - b, 0);

        // R5: read miss on a Modified copy
        m = n_memrd;
        acc(1, 1'b0, 6'd5, '0, q);
        chk(q == 16'h2222, "R5 supplied data", int'(q), 16'h2222);
        chk(mem[5] == 16'h2222, "R5 copied back", int'(mem[5]), 16'h2222);
        chk(n_memrd == m, "R5 memory abandoned", n_memrd - m, 0);
        b = n_inv;
        acc(0, 1'b1, 6'd5, 16'h3333, q);
        chk(n_inv - b == 1, "R5 supplier Shared, R7 invalidate", n_inv - b, 1);
        b = n_rd;
        acc(1, 1'b0, 6'd5, '0, q);
        chk(q == 16'h3333 && n_rd - b == 1, "R7 sharer invalidated", int'(q), 16'h3333);

        // R4: third reader served from a cache, sharers stay Shared
        m = n_memrd;
        acc(2, 1'b0, 6'd5, '0, q);
        chk(q == 16'h3333, "R4 shared supply data", int'(q), 16'h3333);
        chk(n_memrd == m, "R4 memory abandoned", n_memrd - m, 0);
        b = n_inv;
        acc(1, 1'b1, 6'd5, 16'h4444, q);
        chk(n_inv - b == 1, "R4 other copy stayed Shared", n_inv - b, 1);
        acc(0, 1'b0, 6'd5, '0, q);
        chk(q == 16'h4444, "R7 cache 0 sees new data", int'(q), 16'h4444);
        acc(2, 1'b0, 6'd5, '0, q);
        chk(q == 16'h4444, "R7 cache 2 sees new data", int'(q), 16'h4444);

        // R4: read miss on an Exclusive copy
        do_reset();
        acc(0, 1'b0, 6'd20, '0, q);
        m = n_memrd;
        acc(1, 1'b0, 6'd20, '0, q);
        chk(q == 16'hA014 && n_memrd == m, "R4 supply from Exclusive", n_memrd - m, 0);
        b = n_inv;
        acc(0, 1'b1, 6'd20, 16'h5555, q);
        chk(n_inv - b == 1, "R4 supplier now Shared", n_inv - b, 1);

        // R8: write miss with a clean copy elsewhere
        do_reset();
        acc(0, 1'b0, 6'd9, '0, q);
        m = n_memrd;
        b = n_rdx;
        acc(1, 1'b1, 6'd9, 16'h6666, q);
        chk(n_rdx - b == 1 && n_memrd - m == 1, "R8 exclusive read from memory", n_memrd - m, 1);
        b = n_rd;
        acc(0, 1'b0, 6'd9, '0, q);
        chk(q == 16'h6666 && n_rd - b == 1, "R8 old copy invalidated", int'(q), 16'h6666);

        // R9: write miss on a Modified copy
        do_reset();
        acc(0, 1'b1, 6'd10, 16'h7777, q);
        b = n_rdx;
        r = n_retry;
        acc(1, 1'b1, 6'd10, 16'h8888, q);
        chk(n_retry - r == 1, "R9 retry", n_retry - r, 1);
        chk(n_rdx - b == 2, "R9 reissue", n_rdx - b, 2);
        chk(mem[10] == 16'h7777, "R9 write-back", int'(mem[10]), 16'h7777);
        b = total_tx();
        acc(1, 1'b0, 6'd10, '0, q);
        chk(q == 16'h8888 && total_tx() == b, "R9 requester Modified", int'(q), 16'h8888);
        acc(0, 1'b0, 6'd10, '0, q);
        chk(q == 16'h8888, "R9 holder Invalid", int'(q), 16'h8888);

        // R10: dirty and clean victims
        do_reset();
        acc(0, 1'b1, 6'd3, 16'h9999, q);
        b = n_wb;
        acc(0, 1'b0, 6'd7, '0, q);
        chk(n_wb - b == 1 && mem[3] == 16'h9999, "R10 dirty victim written", int'(mem[3]), 16'h9999);
        chk(q == 16'hA007, "R10 fill after write-back", int'(q), 16'hA007);
        b = n_wb;
        acc(0, 1'b0, 6'd11, '0, q);
        chk(n_wb == b && q == 16'hA00B, "R10 clean victim silent", n_wb - b, 0);

        // R11: same set, different tag
        do_reset();
        acc(0, 1'b0, 6'd2, '0, q);
        acc(1, 1'b0, 6'd6, '0, q);
        b = total_tx();
        acc(0, 1'b1, 6'd2, 16'hAAAA, q);
        chk(total_tx() == b, "R11 cache 0 kept Exclusive", total_tx() - b, 0);
        acc(1, 1'b1, 6'd6, 16'hBBBB, q);
        chk(total_tx() == b, "R11 cache 1 got Exclusive", total_tx() - b, 0);

        // R12: two writers race to one address
        do_reset();
        r = n_retry;
        fork
            acc(0, 1'b1, 6'd12, 16'hC0C0, q0);
            acc(1, 1'b1, 6'd12, 16'hC1C1, q1);
        join
        acc(2, 1'b0, 6'd12, '0, q);
        chk(q == 16'hC1C1, "R12 last granted writer wins", int'(q), 16'hC1C1);
        chk(n_retry - r == 1, "R12 serialized by retry", n_retry - r, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule